// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 64 interrupt request lines and presents a single interrupt output to a processor, together with a readable vector that names the source to serve. Software programs it over a simple 32-bit register bus: each source has an enable bit and a configuration word that selects edge or level sensing and a 4-bit priority level.

In a handler, software reads the vector register. A number below 64 names the winning source and puts the controller in service. A value of 64 means nothing was pending and the interrupt is spurious. The output then stays low until software writes the end-of-interrupt register, after which any source of any priority may be delivered again. The output also stays low until the global enable bit is set. A soft reset write clears every register.

Register offsets (byte addresses): 0x000 control (bit 0 = global enable), 0x004 soft reset (bit 0), 0x008 / 0x00C enable set for sources 0-31 / 32-63, 0x010 / 0x014 enable clear for sources 0-31 / 32-63, 0x018 end of interrupt, 0x01C vector. Per-source configuration words sit at 0x200 + 8*n, with the edge select in bit 7 and the priority in bits 3:0. A read of a set or clear register returns the current enables of that half.

Top module: `vectorIrqCtrl`

## Requirements
- R1: After reset the control word, both enable halves and every configuration word read 0, the vector reads 64 and irqOut is low.
- R2: A write to 0x008 (0x00C) sets enable n (n+32) for each 1 in data bit n; bits written 0 leave their enables unchanged. Read back at the same offset.
- R3: A write to 0x010 (0x014) clears enable n (n+32) for each 1 in data bit n; bits written 0 leave their enables unchanged.
- R4: A write to 0x200 + 8*n stores bit 7 (1 = edge) and bits 3:0 (priority) for source n; a read at that address returns them, with all other bits 0.
- R5: A level-configured source is pending exactly while its input is high.
- R6: An edge-configured source becomes pending on a rising edge of its input and stays pending after the input falls. The pending state is cleared by writing its configuration word with bit 7 at 0. Restoring bit 7 to 1 does not bring it back.
- R7: The vector is the pending enabled source with the highest priority; on equal priority the lowest number wins; it is 64 when none is pending and never exceeds 64.
- R8: irqOut is high only when control bit 0 is 1; writing control bit 0 as 0 drops it by the next cycle.
- R9: A vector read that returns a value below 64 holds irqOut low from the next cycle until a write of any value to 0x018.
- R10: Writing 1 to bit 0 of 0x004 clears the enables, the configuration words, the edge pending states, the global enable and the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (not together with wrEn) |
| addr | input | 10 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rdEn |
| irqIn | input | 64 | Interrupt request lines |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
A stuck in-service flag shows as irqOut staying low after the end-of-interrupt write, visible in the very next cycle. A wrong enable, priority or edge pending bit shows as a wrong vector number at the next vector read, so the bench reads the vector after every change of inputs or configuration. A lost edge pending bit shows as the vector falling back to 64 once the input pulse has ended, and a pending bit that is not cleared shows as its number persisting after the configuration rewrite.

// File: rtl/vicPkg.sv
package vicPkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_RST   = 'h04;
  localparam int OFF_SETLO = 'h08;
  localparam int OFF_SETHI = 'h0C;
  localparam int OFF_CLRLO = 'h10;
  localparam int OFF_CLRHI = 'h14;
  localparam int OFF_EOI   = 'h18;
  localparam int OFF_VEC   = 'h1C;
  localparam int EDGE_BIT  = 7;

  typedef struct packed {
    logic       softRst;
    logic [1:0] setEn;
    logic [1:0] clrEn;
    logic       cfgWr;
  } vicStrobes_t;
endpackage

// File: rtl/vicDatapath.sv
module vicDatapath
  import vicPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int VEC_W   = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  vicStrobes_t        stb,
  input  logic [SRC_W-1:0]   cfgIdx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [NUM_SRC-1:0] enables,
  output logic [DATA_W-1:0]  cfgRd,
  output logic [VEC_W-1:0]   vecNum,
  output logic               candAny
);
  localparam int HALF = NUM_SRC / 2;

  logic [NUM_SRC-1:0] edgeSel;
  logic [PRIO_W-1:0]  prio [NUM_SRC];
  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] edgeLatch;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] cand;

  // enable halves: write-one-to-set and write-one-to-clear
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enables[h*HALF +: HALF] <= '0;
      else if (stb.softRst) enables[h*HALF +: HALF] <= '0;
      else if (stb.setEn[h])
        enables[h*HALF +: HALF] <= enables[h*HALF +: HALF] | wdata[HALF-1:0];
      else if (stb.clrEn[h])
        enables[h*HALF +: HALF] <= enables[h*HALF +: HALF] & ~wdata[HALF-1:0];
    end
  end

  // per-source configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSel <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= '0;
    end else if (stb.softRst) begin
      edgeSel <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= '0;
    end else if (stb.cfgWr) begin
      edgeSel[cfgIdx] <= wdata[EDGE_BIT];
      prio[cfgIdx]    <= wdata[PRIO_W-1:0];
    end
  end

  // edge capture, cleared by a configuration write with the edge bit low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrev   <= '0;
      edgeLatch <= '0;
    end else begin
      irqPrev <= irqIn;
      if (stb.softRst) edgeLatch <= '0;
      else begin
        edgeLatch <= edgeLatch | (irqIn & ~irqPrev & edgeSel);
        if (stb.cfgWr && !wdata[EDGE_BIT]) edgeLatch[cfgIdx] <= 1'b0;
      end
    end
  end

  assign pending = (edgeSel & edgeLatch) | (~edgeSel & irqIn);
  assign cand    = pending & enables;
  assign candAny = |cand;

  // arbitration: highest level, ties to the lowest number
  always_comb begin
    logic             hit;
    logic [PRIO_W-1:0] bestPrio;
    hit      = 1'b0;
    bestPrio = '0;
    vecNum   = VEC_W'(NUM_SRC);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!hit || prio[i] > bestPrio)) begin
        hit      = 1'b1;
        bestPrio = prio[i];
        vecNum   = VEC_W'(i);
      end
    end
  end

  always_comb begin
    cfgRd                = '0;
    cfgRd[EDGE_BIT]      = edgeSel[cfgIdx];
    cfgRd[PRIO_W-1:0]    = prio[cfgIdx];
  end
endmodule

// File: rtl/vicCtrl.sv
module vicCtrl
  import vicPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = $clog2(NUM_SRC),
  parameter int VEC_W   = $clog2(NUM_SRC) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wBit0,
  input  logic [NUM_SRC-1:0] enables,
  input  logic [DATA_W-1:0]  cfgRd,
  input  logic [VEC_W-1:0]   vecNum,
  input  logic               candAny,
  output vicStrobes_t        stb,
  output logic [SRC_W-1:0]   cfgIdx,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqOut
);
  localparam int HALF = NUM_SRC / 2;

  logic       isReg;
  logic       isCfg;
  logic [4:0] regOff;
  logic       genEn;
  logic       inService;
  logic       eoiWr;
  logic       vecTake;

  assign isReg  = (addr[ADDR_W-1:5] == '0);
  assign regOff = addr[4:0];
  assign isCfg  = addr[ADDR_W-1] && (addr[2:0] == 3'b000);
  assign cfgIdx = addr[3 +: SRC_W];

  always_comb begin
    stb         = '0;
    stb.softRst = wrEn && isReg && regOff == 5'(OFF_RST) && wBit0;
    stb.setEn   = {wrEn && isReg && regOff == 5'(OFF_SETHI),
                   wrEn && isReg && regOff == 5'(OFF_SETLO)};
    stb.clrEn   = {wrEn && isReg && regOff == 5'(OFF_CLRHI),
                   wrEn && isReg && regOff == 5'(OFF_CLRLO)};
    stb.cfgWr   = wrEn && isCfg;
  end

  assign eoiWr   = wrEn && isReg && regOff == 5'(OFF_EOI);
  assign vecTake = rdEn && isReg && regOff == 5'(OFF_VEC) && vecNum < VEC_W'(NUM_SRC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genEn     <= 1'b0;
      inService <= 1'b0;
    end else if (stb.softRst) begin
      genEn     <= 1'b0;
      inService <= 1'b0;
    end else begin
      if (wrEn && isReg && regOff == 5'(OFF_CTRL)) genEn <= wBit0;
      if (eoiWr) inService <= 1'b0;
      else if (vecTake) inService <= 1'b1;
    end
  end

  assign irqOut = genEn && !inService && candAny;

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      if (isCfg) rdata = cfgRd;
      else if (isReg) begin
        case (regOff)
          5'(OFF_CTRL):  rdata = DATA_W'(genEn);
          5'(OFF_SETLO),
          5'(OFF_CLRLO): rdata = DATA_W'(enables[HALF-1:0]);
          5'(OFF_SETHI),
          5'(OFF_CLRHI): rdata = DATA_W'(enables[NUM_SRC-1:HALF]);
          5'(OFF_VEC):   rdata = DATA_W'(vecNum);
          default:       rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/vectorIrqCtrl.sv
module vectorIrqCtrl
  import vicPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqOut
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int VEC_W = SRC_W + 1;

  vicStrobes_t        stb;
  logic [SRC_W-1:0]   cfgIdx;
  logic [NUM_SRC-1:0] enables;
  logic [DATA_W-1:0]  cfgRd;
  logic [VEC_W-1:0]   vecNum;
  logic               candAny;

  vicCtrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wBit0(wdata[0]), .enables(enables), .cfgRd(cfgRd), .vecNum(vecNum),
    .candAny(candAny), .stb(stb), .cfgIdx(cfgIdx), .rdata(rdata), .irqOut(irqOut)
  );

  vicDatapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIdx(cfgIdx), .wdata(wdata),
    .irqIn(irqIn), .enables(enables), .cfgRd(cfgRd), .vecNum(vecNum),
    .candAny(candAny)
  );
endmodule

// File: rtl/vicChk.sv
module vicChk
  import vicPkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = $clog2(NUM_SRC) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wBit0,
  input logic [DATA_W-1:0] rdata,
  input logic              irqOut,
  input logic [VEC_W-1:0]  vecNum
);
  // R10
  soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_RST) && wBit0) |=> !irqOut);

  // R8
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_CTRL) && !wBit0) |=> !irqOut);

  // R9
  in_service_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == ADDR_W'(OFF_VEC) && rdata < DATA_W'(NUM_SRC)) |=> !irqOut);

  // R7
  valid_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> vecNum < VEC_W'(NUM_SRC));

  // R7
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecNum <= VEC_W'(NUM_SRC));
endmodule

bind vectorIrqCtrl vicChk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wBit0(wdata[0]), .rdata(rdata), .irqOut(irqOut), .vecNum(vecNum)
);

// File: tb/vectorIrqCtrl_tb.sv
`timescale 1ns/1ps
module vectorIrqCtrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] irqIn = '0;
  logic        irqOut;

  always #2.5 clk = ~clk;

  vectorIrqCtrl u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irqIn(irqIn), .irqOut(irqOut));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [63:0] mEn = '0, mEdge = '0, mLatch = '0, curIn = '0;
  logic [3:0]  mPrio [64];
  logic        mGen = 1'b0, mSvc = 1'b0;

  function automatic logic [9:0] cfgAddr(input int n);
    return 10'(512 + n * 8);
  endfunction

  function automatic int expVec();
    int best = 64;
    int bp = -1;
    for (int i = 0; i < 64; i++) begin
      logic pend = mEdge[i] ? mLatch[i] : curIn[i];
      if (pend && mEn[i] && int'(mPrio[i]) > bp) begin
        bp = int'(mPrio[i]);
        best = i;
      end
    end
    return best;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [9:0] a, input logic [31:0] d);
    case (a)
      10'h000: mGen = d[0];
      10'h004: if (d[0]) begin
        mEn = '0; mEdge = '0; mLatch = '0; mGen = 1'b0; mSvc = 1'b0;
        for (int i = 0; i < 64; i++) mPrio[i] = '0;
      end
      10'h008: mEn[31:0]  = mEn[31:0] | d;
      10'h00C: mEn[63:32] = mEn[63:32] | d;
      10'h010: mEn[31:0]  = mEn[31:0] & ~d;
      10'h014: mEn[63:32] = mEn[63:32] & ~d;
      10'h018: mSvc = 1'b0;
      default: if (a[9] && a[2:0] == 3'b000) begin
        mEdge[a[8:3]] = d[7];
        mPrio[a[8:3]] = d[3:0];
        if (!d[7]) mLatch[a[8:3]] = 1'b0;
      end
    endcase
  endtask

  task automatic busWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
    if (a == 10'h01C && d < 64) mSvc = 1'b1;
  endtask

  task automatic setIrq(input logic [63:0] v);
    @(negedge clk);
    mLatch = mLatch | (mEdge & v & ~curIn);
    irqIn = v;
    curIn = v;
    @(negedge clk);
  endtask

  task automatic checkIrq(input string req);
    #1 check(req, 32'(irqOut), 32'(mGen && !mSvc && expVec() < 64));
  endtask

  task automatic checkVec(input string req);
    logic [31:0] d;
    int e = expVec();
    busRead(10'h01C, d);
    check(req, d, 32'(e));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) mPrio[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 check("R1 irqOut", 32'(irqOut), 0);
    busRead(10'h000, d); check("R1 ctrl", d, 0);
    busRead(10'h008, d); check("R1 enLo", d, 0);
    busRead(10'h00C, d); check("R1 enHi", d, 0);
    busRead(cfgAddr(40), d); check("R1 cfg", d, 0);
    busRead(10'h01C, d); check("R1 vector", d, 64);

    // R2 set with zero bits ignored
    busWrite(10'h008, 32'h1);
    busWrite(10'h008, 32'h4);
    busRead(10'h008, d); check("R2 set lo", d, 32'h5);
    busWrite(10'h00C, 32'h8000_0000);
    busRead(10'h00C, d); check("R2 set hi", d, 32'h8000_0000);
    busRead(10'h008, d); check("R2 lo unchanged", d, 32'h5);

    // R3 clear with zero bits ignored
    busWrite(10'h010, 32'h0);
    busRead(10'h010, d); check("R3 zero clear", d, 32'h5);
    busWrite(10'h010, 32'h1);
    busRead(10'h008, d); check("R3 clear lo", d, 32'h4);

    // R4 configuration layout
    busWrite(cfgAddr(5), 32'hFFFF_FF83);
    busRead(cfgAddr(5), d); check("R4 cfg readback", d, 32'h83);
    busWrite(cfgAddr(5), 32'h0);

    // R5 level source, R8 global enable gating
    busWrite(cfgAddr(2), 32'h03);
    setIrq(64'h4);
    checkIrq("R8 gated off");
    check("R8 gated off value", 32'(irqOut), 0);
    checkVec("R5 level high");
    busWrite(10'h018, 0);
    busWrite(10'h000, 32'h1);
    #1 check("R8 enabled", 32'(irqOut), 1);

    // R9 in service until end of interrupt
    busRead(10'h01C, d); check("R9 vector", d, 2);
    #1 check("R9 held low", 32'(irqOut), 0);
    repeat (5) @(negedge clk);
    #1 check("R9 still low", 32'(irqOut), 0);
    busWrite(10'h018, 32'hDEAD);
    #1 check("R9 after eoi", 32'(irqOut), 1);

    // R7 priority and tie order
    busWrite(cfgAddr(63), 32'h03);
    setIrq(64'h8000_0000_0000_0004);
    busRead(10'h01C, d); check("R7 tie lowest", d, 2);
    busWrite(10'h018, 0);
    busWrite(cfgAddr(63), 32'h05);
    busRead(10'h01C, d); check("R7 higher prio", d, 63);
    busWrite(10'h018, 0);

    // R5 level drop
    setIrq(64'h0);
    busRead(10'h01C, d); check("R5 level low", d, 64);
    #1 check("R7 spurious no irq", 32'(irqOut), 0);

    // R6 edge capture and clear
    busWrite(10'h00C, 32'h100);
    busWrite(cfgAddr(40), 32'h87);
    setIrq(64'h1 << 40);
    setIrq(64'h0);
    busRead(10'h01C, d); check("R6 edge latched", d, 40);
    busWrite(10'h018, 0);
    busRead(10'h01C, d); check("R6 edge persists", d, 40);
    busWrite(10'h018, 0);
    busWrite(cfgAddr(40), 32'h07);
    busRead(10'h01C, d); check("R6 cleared", d, 64);
    busWrite(cfgAddr(40), 32'h87);
    busRead(10'h01C, d); check("R6 stays cleared", d, 64);

    // R10 soft reset
    setIrq(64'h4);
    busWrite(10'h004, 32'h1);
    #1 check("R10 irqOut", 32'(irqOut), 0);
    busRead(10'h000, d); check("R10 ctrl", d, 0);
    busRead(10'h008, d); check("R10 enLo", d, 0);
    busRead(10'h00C, d); check("R10 enHi", d, 0);
    busRead(cfgAddr(63), d); check("R10 cfg", d, 0);
    busRead(10'h01C, d); check("R10 vector", d, 64);
    setIrq(64'h0);

    // random phase against the model
    busWrite(10'h000, 32'h1);
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: begin
          int n = $urandom_range(0, 63);
          busWrite(cfgAddr(n), {24'h0, 1'($urandom_range(0, 1)), 3'b0, 4'($urandom_range(0, 15))});
          busRead(cfgAddr(n), d);
          check("R4 random cfg", d, {24'h0, mEdge[n], 3'b0, mPrio[n]});
        end
        1: begin
          logic [9:0] a = $urandom_range(0, 1) ? 10'h008 : 10'h00C;
          busWrite(a, $urandom() & $urandom());
          busRead(a, d);
          check("R2 random set", d, a == 10'h008 ? mEn[31:0] : mEn[63:32]);
        end
        2: begin
          logic [9:0] a = $urandom_range(0, 1) ? 10'h010 : 10'h014;
          busWrite(a, $urandom() & $urandom() & $urandom());
          busRead(a, d);
          check("R3 random clear", d, a == 10'h010 ? mEn[31:0] : mEn[63:32]);
        end
        3, 4: begin
          logic [63:0] v = curIn;
          v[$urandom_range(0, 63)] ^= 1'b1;
          if ($urandom_range(0, 3) == 0) v[$urandom_range(0, 63)] ^= 1'b1;
          setIrq(v);
          checkVec("R7 random vector");
        end
        5: checkVec("R7 random read");
        6: busWrite(10'h018, $urandom());
        default: busWrite(10'h000, 32'($urandom_range(0, 4) != 0));
      endcase
      checkIrq("R9 random irqOut");
    end

    finishRun();
  end
endmodule